// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the stream of byte addresses for a single DMA channel. A requester programs a start address, a row length (X count), an in-row stride (X modify), a row total (Y count) and a between-row stride (Y modify), picks an element size, and pulses `start`. The generator then shows one address at a time. It moves to the next address only when the requester accepts the current one through `xfer_ack`. Data movement, descriptor fetch and bus arbitration are done elsewhere.

Both strides are signed element counts. The element size scales them to bytes. The stride applied at a row end replaces the in-row stride, so it may be smaller or negative. This lets one pass de-interleave a stream stored with several channels side by side. In one-dimensional operation only the X fields are used. When the buffer is complete, the generator either stops and raises `done`, or, in circular operation, goes back to the start address and keeps going. An interrupt pulse marks buffer completion. When enabled, an interrupt pulse also marks every row end, which gives partial-buffer notification.

Top module: `dma2d_addr_gen`

## Requirements
- R1: A `start` pulse captures the whole configuration. On the next clock `addr_valid` is 1, `addr` equals `cfg_start_addr`, `done` is 0 and `irq` is 0. A `start` pulse while a pass is running restarts the pass.
- R2: When `addr_valid` is 1 and `xfer_ack` is 1 at a rising edge, the next address is presented after that edge. While `xfer_ack` is 0, `addr` and `addr_valid` stay unchanged.
- R3: The strides are scaled by the element size code `cfg_elem_size`: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 gives 4 bytes. Within a row, each accepted element adds the sign-extended `cfg_x_mod` times the size to the address.
- R4: When `cfg_two_d` is 1 and the accepted element is the last of a row but not the last row, the next address is the current address plus the scaled `cfg_y_mod`, and not the X stride. The row restarts with the full X count.
- R5: `cfg_y_mod` may be negative or smaller than `cfg_x_mod`, and the address arithmetic wraps modulo 2^32. This lets an interleaved buffer be walked one channel at a time.
- R6: When `cfg_circular` is 0, accepting the last element of the buffer gives `addr_valid` = 0, `done` = 1 and a one-cycle `irq` pulse on the following clock. `done` stays 1 until the next `start`. The last element is the last of the row in 1-D mode, or the last of the last row in 2-D mode.
- R7: When `cfg_circular` is 1, accepting the last element of the buffer gives `addr` = start address, reloads both counts, keeps `addr_valid` at 1 and `done` at 0, and gives a one-cycle `irq` pulse.
- R8: When `cfg_row_irq` is 1 in 2-D mode, accepting the last element of each row gives a one-cycle `irq` pulse on the following clock. When `cfg_row_irq` is 0, only buffer completion pulses `irq`.
- R9: An X or Y count of 0 means 65536 elements.
- R10: While and right after reset, `addr_valid`, `done` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture configuration and begin a pass |
| cfg_start_addr | input | 32 | Byte address of the first element |
| cfg_x_count | input | 16 | Elements per row (0 = 65536) |
| cfg_x_mod | input | 16 | Signed in-row stride in elements |
| cfg_y_count | input | 16 | Rows per buffer in 2-D mode (0 = 65536) |
| cfg_y_mod | input | 16 | Signed row-end stride in elements |
| cfg_two_d | input | 1 | 1 = two-dimensional pattern |
| cfg_circular | input | 1 | 1 = restart from start address after the last element |
| cfg_row_irq | input | 1 | 1 = also pulse irq at each row end |
| cfg_elem_size | input | 2 | Element size code: 0 = 1 B, 1 = 2 B, 2/3 = 4 B |
| xfer_ack | input | 1 | Requester accepted the current address |
| addr_valid | output | 1 | `addr` holds a valid element address |
| addr | output | 32 | Current element byte address |
| done | output | 1 | Non-circular pass finished |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong count register first shows up as a row-end stride taken at the wrong element. Because every accepted address is compared, the bad address is seen on the clock right after the faulty acceptance. It also shows as an `irq` pulse or `done` that comes one or more elements early or late. A corrupted stride or element-size decode shows up on the first in-row step after `start`. A loss of the count-of-zero meaning only shows at the end of a 65536-element row, so that case is run in full.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE  = 2'd0,
    ESZ_HALF  = 2'd1,
    ESZ_WORD  = 2'd2,
    ESZ_WORD2 = 2'd3
  } elem_size_e;

  // log2 of the element size in bytes
  function automatic logic [1:0] size_shift(input elem_size_e esz);
    case (esz)
      ESZ_BYTE: size_shift = 2'd0;
      ESZ_HALF: size_shift = 2'd1;
      default:  size_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_step_scale.sv
module dma2d_step_scale
  import dma2d_pkg::*;
#(
  parameter int MOD_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [MOD_W-1:0]  mod_elems,
  input  logic [1:0]        elem_size,
  output logic [ADDR_W-1:0] step_bytes
);
  localparam int EXT_W = ADDR_W - MOD_W;

  logic [ADDR_W-1:0] ext;

  always_comb begin
    ext        = {{EXT_W{mod_elems[MOD_W-1]}}, mod_elems};
    step_bytes = ext << size_shift(elem_size_e'(elem_size));
  end

endmodule

// File: rtl/dma2d_down_cnt.sv
module dma2d_down_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_last
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= CW'(1);
    else if (load) cnt <= {(load_val == '0), load_val};   // zero means 2^CNT_W
    else if (dec)  cnt <= cnt - CW'(1);
  end

  assign at_last = (cnt == CW'(1));

  // R9: the count never wraps through zero
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> !at_last);
  a_r9_nonzero: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [CNT_W-1:0]  cfg_x_count,
  input  logic [MOD_W-1:0]  cfg_x_mod,
  input  logic [CNT_W-1:0]  cfg_y_count,
  input  logic [MOD_W-1:0]  cfg_y_mod,
  input  logic              cfg_two_d,
  input  logic              cfg_circular,
  input  logic              cfg_row_irq,
  input  logic [1:0]        cfg_elem_size,
  input  logic              xfer_ack,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              irq
);

  // captured configuration
  logic [ADDR_W-1:0] base_q, xstep_q, ystep_q;
  logic [CNT_W-1:0]  xcnt_q, ycnt_q;
  logic              two_d_q, circ_q, rowirq_q;

  logic [ADDR_W-1:0] xstep_d, ystep_d;

  dma2d_step_scale #(.MOD_W(MOD_W), .ADDR_W(ADDR_W)) u_xscale (
    .mod_elems(cfg_x_mod), .elem_size(cfg_elem_size), .step_bytes(xstep_d));
  dma2d_step_scale #(.MOD_W(MOD_W), .ADDR_W(ADDR_W)) u_yscale (
    .mod_elems(cfg_y_mod), .elem_size(cfg_elem_size), .step_bytes(ystep_d));

  logic adv, x_last, y_last, buf_last;

  assign adv      = addr_valid && xfer_ack && !start;
  assign buf_last = x_last && (!two_d_q || y_last);

  dma2d_down_cnt #(.CNT_W(CNT_W)) u_xcnt (
    .clk(clk), .rst(rst),
    .load(start || (adv && x_last)),
    .load_val(start ? cfg_x_count : xcnt_q),
    .dec(adv && !x_last),
    .at_last(x_last));

  dma2d_down_cnt #(.CNT_W(CNT_W)) u_ycnt (
    .clk(clk), .rst(rst),
    .load(start || (adv && buf_last)),
    .load_val(start ? cfg_y_count : ycnt_q),
    .dec(adv && x_last && !buf_last),
    .at_last(y_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
      addr       <= '0;
      base_q     <= '0;
      xstep_q    <= '0;
      ystep_q    <= '0;
      xcnt_q     <= '0;
      ycnt_q     <= '0;
      two_d_q    <= 1'b0;
      circ_q     <= 1'b0;
      rowirq_q   <= 1'b0;
    end else if (start) begin
      addr_valid <= 1'b1;
      done       <= 1'b0;
      irq        <= 1'b0;
      addr       <= cfg_start_addr;
      base_q     <= cfg_start_addr;
      xstep_q    <= xstep_d;
      ystep_q    <= ystep_d;
      xcnt_q     <= cfg_x_count;
      ycnt_q     <= cfg_y_count;
      two_d_q    <= cfg_two_d;
      circ_q     <= cfg_circular;
      rowirq_q   <= cfg_row_irq;
    end else begin
      irq <= 1'b0;
      if (adv) begin
        if (buf_last) begin
          irq <= 1'b1;
          if (circ_q) begin
            addr <= base_q;
          end else begin
            addr_valid <= 1'b0;
            done       <= 1'b1;
          end
        end else if (x_last) begin
          addr <= addr + ystep_q;
          irq  <= rowirq_q;
        end else begin
          addr <= addr + xstep_q;
        end
      end
    end
  end

  // R1: a start pulse presents the start address on the next clock
  a_r1_start_load: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr_valid && !done && addr == $past(cfg_start_addr)));

  // R2: without acceptance the presented address is held
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !xfer_ack && !start) |=> (addr_valid && $stable(addr)));

  // R6: finished and presenting an address are exclusive
  a_r6_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && addr_valid));

  // R6/R8: an interrupt pulse always follows an accepted element
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(adv));

  // R7: circular operation never drops the valid address
  a_r7_circ_keeps: assert property (@(posedge clk) disable iff (rst)
    (adv && circ_q) |=> addr_valid);

endmodule

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_start_addr = '0;
  logic [15:0] cfg_x_count = '0, cfg_x_mod = '0, cfg_y_count = '0, cfg_y_mod = '0;
  logic        cfg_two_d = 1'b0, cfg_circular = 1'b0, cfg_row_irq = 1'b0;
  logic [1:0]  cfg_elem_size = '0;
  logic        xfer_ack = 1'b0;
  logic        addr_valid, done, irq;
  logic [31:0] addr;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [31:0] m_addr, m_base;
  int          m_x, m_y, m_xr, m_yr, m_xs, m_ys;
  logic        m_two_d, m_circ, m_rowirq, m_valid, m_done;

  always #2.5 clk = ~clk;   // 200 MHz

  dma2d_addr_gen dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_start_addr(cfg_start_addr), .cfg_x_count(cfg_x_count), .cfg_x_mod(cfg_x_mod),
    .cfg_y_count(cfg_y_count), .cfg_y_mod(cfg_y_mod), .cfg_two_d(cfg_two_d),
    .cfg_circular(cfg_circular), .cfg_row_irq(cfg_row_irq), .cfg_elem_size(cfg_elem_size),
    .xfer_ack(xfer_ack), .addr_valid(addr_valid), .addr(addr), .done(done), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // program and start a pass; called at a falling edge
  task automatic begin_pass(input logic [31:0] sa, input logic [15:0] xc, input int xm,
                            input logic [15:0] yc, input int ym, input logic two_d,
                            input logic circ, input logic rowirq, input logic [1:0] esz);
    int sc;
    cfg_start_addr = sa; cfg_x_count = xc; cfg_x_mod = 16'(xm);
    cfg_y_count = yc; cfg_y_mod = 16'(ym); cfg_two_d = two_d;
    cfg_circular = circ; cfg_row_irq = rowirq; cfg_elem_size = esz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sc = (esz == 2'd0) ? 1 : (esz == 2'd1) ? 2 : 4;       // R3 size decode
    m_base = sa; m_addr = sa;
    m_xr = (xc == 0) ? 65536 : int'(xc);                   // R9
    m_yr = (yc == 0) ? 65536 : int'(yc);
    m_x = m_xr; m_y = m_yr;
    m_xs = xm * sc; m_ys = ym * sc;
    m_two_d = two_d; m_circ = circ; m_rowirq = rowirq;
    m_valid = 1'b1; m_done = 1'b0;
    check("R1 valid after start", 32'(addr_valid), 32'd1);
    check("R1 start address", addr, sa);
    check("R1 done cleared", 32'(done), 32'd0);
    check("R1 irq quiet", 32'(irq), 32'd0);
  endtask

  // accept the current address and check what follows; called at a falling edge
  task automatic accept(input string req);
    logic e_irq;
    check({req, " addr before accept"}, addr, m_addr);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    e_irq = 1'b0;
    if (m_x == 1) begin
      if (m_two_d && m_y != 1) begin            // R4 row end
        m_addr = m_addr + 32'(m_ys);
        m_x = m_xr; m_y = m_y - 1;
        e_irq = m_rowirq;                       // R8
      end else begin                            // buffer end
        e_irq = 1'b1;
        if (m_circ) begin                       // R7
          m_addr = m_base; m_x = m_xr; m_y = m_yr;
        end else begin                          // R6
          m_valid = 1'b0; m_done = 1'b1;
        end
      end
    end else begin
      m_addr = m_addr + 32'(m_xs);              // R2/R3
      m_x = m_x - 1;
    end
    check({req, " valid"}, 32'(addr_valid), 32'(m_valid));
    check({req, " done"}, 32'(done), 32'(m_done));
    check({req, " irq"}, 32'(irq), 32'(e_irq));
    if (m_valid) check({req, " next addr"}, addr, m_addr);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 valid in reset", 32'(addr_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 valid after reset", 32'(addr_valid), 32'd0);
    check("R10 done after reset", 32'(done), 32'd0);
    check("R10 irq after reset", 32'(irq), 32'd0);
  endtask

  task automatic t_linear_stop;
    begin_pass(32'h0000_1000, 16'd5, 1, 16'd1, 0, 1'b0, 1'b0, 1'b0, 2'd2);
    check("R3 word first", addr, 32'h0000_1000);
    for (int i = 0; i < 5; i++) accept("R6 linear stop");
    @(negedge clk);
    check("R6 done holds", 32'(done), 32'd1);
    check("R6 irq single pulse", 32'(irq), 32'd0);
  endtask

  task automatic t_byte_negative;
    begin_pass(32'h0000_0010, 16'd4, -3, 16'd9, 7, 1'b0, 1'b0, 1'b0, 2'd0);
    for (int i = 0; i < 4; i++) accept("R3 byte negative stride");
  endtask

  task automatic t_two_d_rowirq;
    begin_pass(32'h2000_0000, 16'd3, 2, 16'd3, 10, 1'b1, 1'b0, 1'b1, 2'd1);
    for (int i = 0; i < 9; i++) accept("R8 two-d with row irq");
    begin_pass(32'h2000_0000, 16'd3, 2, 16'd2, 10, 1'b1, 1'b0, 1'b0, 2'd3);
    for (int i = 0; i < 6; i++) accept("R4 two-d row stride");
  endtask

  task automatic t_deinterleave;
    // three channels of 4 samples interleaved: 0,3,6,9 then 1,4,7,10 then 2,...
    begin_pass(32'h0000_0000, 16'd4, 3, 16'd3, -8, 1'b1, 1'b0, 1'b0, 2'd0);
    accept("R5 deinterleave"); accept("R5 deinterleave");
    accept("R5 deinterleave"); accept("R5 deinterleave");
    check("R5 second channel start", addr, 32'd1);
    for (int i = 0; i < 8; i++) accept("R5 deinterleave");
    // wrap below zero
    begin_pass(32'h0000_0002, 16'd2, 1, 16'd2, -5, 1'b1, 1'b0, 1'b0, 2'd0);
    for (int i = 0; i < 4; i++) accept("R5 wrap below zero");
  endtask

  task automatic t_circular;
    begin_pass(32'h0000_0400, 16'd3, 4, 16'd1, 0, 1'b0, 1'b1, 1'b0, 2'd0);
    for (int i = 0; i < 8; i++) accept("R7 circular");
    begin_pass(32'h0000_0800, 16'd2, 1, 16'd2, 3, 1'b1, 1'b1, 1'b0, 2'd2);
    for (int i = 0; i < 9; i++) accept("R7 circular two-d");
    // restart in mid pass
    begin_pass(32'h0000_5000, 16'd2, 1, 16'd1, 0, 1'b0, 1'b0, 1'b0, 2'd0);
    accept("R1 restart"); accept("R1 restart");
  endtask

  task automatic t_stall;
    logic [31:0] held;
    begin_pass(32'h0000_3000, 16'd4, 2, 16'd1, 0, 1'b0, 1'b0, 1'b0, 2'd1);
    accept("R2 stall");
    held = addr;
    repeat (4) @(negedge clk);
    check("R2 addr held without ack", addr, held);
    check("R2 valid held without ack", 32'(addr_valid), 32'd1);
    accept("R2 stall"); accept("R2 stall"); accept("R2 stall");
  endtask

  task automatic t_count_zero;
    begin_pass(32'h1000_0000, 16'd0, 1, 16'd1, 0, 1'b0, 1'b0, 1'b0, 2'd0);
    for (int i = 0; i < 65535; i++) accept("R9 count zero");
    check("R9 not done before last", 32'(done), 32'd0);
    check("R9 last address", addr, 32'h1000_FFFF);
    accept("R9 count zero last");
    check("R9 done after 65536", 32'(done), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_linear_stop();
    t_byte_negative();
    t_two_d_rowirq();
    t_deinterleave();
    t_circular();
    t_stall();
    t_count_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule